// File: doc/BRIEF.md
# Single-Wire Bus Transaction Controller

This block is a register-driven master for a single-wire, open-drain serial bus. It serves up to four sensor boards, and each board has its own bus line. Software writes a one-hot board select and a transaction length, given as the bit count minus one, into the control register. It then requests one transaction: a bus reset pulse, a write of bits taken from the command register, or a read. The result of a read is stored in a row of 16-bit data registers.

Two macro sequencers are built on top of the raw transactions. Each one runs a complete multi-step exchange without software help, and each reports completion through its start bit in the command register:

- The ROM-read sequence performs a reset, sends `0x33` and reads 64 bits.
- The temperature sequence performs a reset, sends skip (`0xCC`) and convert (`0x44`), and waits a programmable time. It then performs a second reset, sends skip and read-scratchpad (`0xBE`), and reads 72 bits.

All bus timing is counted in microseconds from a clock divider. Bits go out and come in LSB first.

Top module: `onewire_xact_ctrl`

## Requirements
- R1: Register 0 (control) keeps the board select in bits 3:0 and the bit count minus one in bits 15:8, and both read back. Bits 6:4 read 0. Only the selected lines are driven low, and a level pulled low on an unselected line does not affect read data.
- R2: Writing control with bit 6 set issues a bus reset. The line is driven low for RST_LOW_US (480) microseconds and then released for RST_REL_US microseconds.
- R3: Writing control with bit 4 set sends count+1 bits, LSB first, from bits 7:0 of register 1 (command). Bits beyond the eighth are sent as 0. Each slot lasts SLOT_US. A 1 is driven low for W1_LOW_US (6 us) and a 0 for W0_LOW_US (58 us).
- R4: Writing control with bit 5 set runs count+1 read slots. Each slot is driven low for W1_LOW_US and sampled SAMPLE_US (15 us) after it starts. Read bit k lands in register 2+k/16 at bit k%16. The read area (registers 2 to 6) is cleared when a read starts, and bits past the 80th are dropped.
- R5: Control bit 7 reads 1 while any transaction or sequence is running, and 0 otherwise.
- R6: A write to control or command while busy is discarded as a whole. It starts nothing and changes no field.
- R7: When several request bits are set in one write, the priorities are reset over write over read, and temperature over ROM.
- R8: Writing command bit 9 runs the ROM sequence. Bit 9 reads 0 from that write until the sequence ends and 1 afterwards. The 64 bits read land in registers 2 to 5, and register 6 reads 0.
- R9: Writing command bit 8 runs the temperature sequence, including the CONV_US wait. Bit 8 reads 0 until the sequence ends and 1 afterwards. The 72 bits read land in registers 2 to 6.
- R10: After reset, every register reads 0 and no line is driven. While the block is idle, no line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 command, 2 to 6 read data) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ow_drive_low | output | 4 | Per-board open-drain pull-down enable |
| ow_sense | input | 4 | Per-board sensed line level |

## Verification
The bench builds the block with CLK_PER_US=2 and CONV_US=20 and keeps the protocol's microsecond timings unchanged. With these values a reset costs under 1,800 cycles and a bit slot about 120 cycles. Both complete macro sequences therefore fit in the run, and so do a 91-bit read that overruns the 80-bit read area and an attempted overlapping request. A bus model measures every pull-down pulse in cycles and answers read slots from a bit pattern.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {OP_END, OP_RST, OP_WR, OP_RD, OP_WAIT} op_kind_e;
  typedef enum logic [2:0] {M_RST, M_WR, M_RD, M_TEMP, M_ROM} mode_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [7:0] data;
    logic [7:0] last;
  } step_t;

  localparam logic [7:0] BYTE_SKIP = 8'hCC;
  localparam logic [7:0] BYTE_CONV = 8'h44;
  localparam logic [7:0] BYTE_SCRP = 8'hBE;
  localparam logic [7:0] BYTE_ROM  = 8'h33;

  function automatic step_t mk(op_kind_e k, logic [7:0] d, logic [7:0] l);
    step_t s;
    s.kind = k;
    s.data = d;
    s.last = l;
    return s;
  endfunction

  // Step list of each run mode; raw modes use the software byte and length.
  function automatic step_t step_at(mode_e m, logic [3:0] idx,
                                    logic [7:0] rb, logic [7:0] rl);
    step_t s;
    s = mk(OP_END, 8'h00, 8'h00);
    case (m)
      M_RST:  if (idx == 4'd0) s = mk(OP_RST, 8'h00, 8'h00);
      M_WR:   if (idx == 4'd0) s = mk(OP_WR, rb, rl);
      M_RD:   if (idx == 4'd0) s = mk(OP_RD, 8'h00, rl);
      M_ROM: begin
        case (idx)
          4'd0: s = mk(OP_RST, 8'h00, 8'h00);
          4'd1: s = mk(OP_WR, BYTE_ROM, 8'd7);
          4'd2: s = mk(OP_RD, 8'h00, 8'd63);
          default: ;
        endcase
      end
      M_TEMP: begin
        case (idx)
          4'd0: s = mk(OP_RST, 8'h00, 8'h00);
          4'd1: s = mk(OP_WR, BYTE_SKIP, 8'd7);
          4'd2: s = mk(OP_WR, BYTE_CONV, 8'd7);
          4'd3: s = mk(OP_WAIT, 8'h00, 8'h00);
          4'd4: s = mk(OP_RST, 8'h00, 8'h00);
          4'd5: s = mk(OP_WR, BYTE_SKIP, 8'd7);
          4'd6: s = mk(OP_WR, BYTE_SCRP, 8'd7);
          4'd7: s = mk(OP_RD, 8'h00, 8'd71);
          default: ;
        endcase
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine #(
  parameter int RST_LOW_US = 480,
  parameter int RST_REL_US = 410,
  parameter int SLOT_US    = 60,
  parameter int W1_LOW_US  = 6,
  parameter int W0_LOW_US  = 58,
  parameter int SAMPLE_US  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic go,
  input  logic go_rst,
  input  logic go_bit,
  input  logic line_in,
  output logic drive_low,
  output logic done,
  output logic rx_bit
);
  localparam int TW = $clog2(RST_LOW_US + RST_REL_US + 1);
  localparam logic [TW-1:0] L_RST   = TW'(RST_LOW_US);
  localparam logic [TW-1:0] E_RST   = TW'(RST_LOW_US + RST_REL_US - 1);
  localparam logic [TW-1:0] L_ONE   = TW'(W1_LOW_US);
  localparam logic [TW-1:0] L_ZERO  = TW'(W0_LOW_US);
  localparam logic [TW-1:0] E_SLOT  = TW'(SLOT_US - 1);
  localparam logic [TW-1:0] SMP_M1  = TW'(SAMPLE_US - 1);

  logic          act_q, act_d;
  logic          rst_q, rst_d;
  logic          bit_q, bit_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          rx_q, rx_d;
  logic          done_q, done_d;
  logic [TW-1:0] low_len, end_at;

  assign low_len   = rst_q ? L_RST : (bit_q ? L_ONE : L_ZERO);
  assign end_at    = rst_q ? E_RST : E_SLOT;
  assign drive_low = act_q && (cnt_q < low_len);
  assign done      = done_q;
  assign rx_bit    = rx_q;

  always_comb begin
    act_d  = act_q;
    rst_d  = rst_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (go) begin
      act_d = 1'b1;
      rst_d = go_rst;
      bit_d = go_bit;
      cnt_d = '0;
    end else if (act_q && us_tick) begin
      cnt_d = cnt_q + 1'b1;
      if (!rst_q && cnt_q == SMP_M1) rx_d = line_in;
      if (cnt_q == end_at) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rst_q  <= 1'b0;
      bit_q  <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      rst_q  <= rst_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  // A new slot never starts on top of a running one.
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !act_q);
endmodule

// File: rtl/owm_sequencer.sv
module owm_sequencer
  import owm_pkg::*;
#(
  parameter int CONV_US = 750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  mode_e      start_mode,
  input  logic [7:0] raw_byte,
  input  logic [7:0] raw_last,
  input  logic       us_tick,
  input  logic       slot_done,
  input  logic       slot_rx,
  output logic       busy,
  output logic       fin,
  output mode_e      run_mode,
  output logic       slot_go,
  output logic       slot_rst,
  output logic       slot_bit,
  output logic       tick_clr,
  output logic       rd_clr,
  output logic       rd_we,
  output logic [7:0] rd_idx,
  output logic       rd_bit
);
  localparam int WCW = $clog2(CONV_US + 1);
  localparam logic [WCW-1:0] WAIT_M1 = WCW'(CONV_US - 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_SLOT, S_PAUSE} st_e;

  st_e            st_q, st_d;
  mode_e          mode_q, mode_d;
  logic [3:0]     step_q, step_d;
  op_kind_e       kind_q, kind_d;
  logic [7:0]     last_q, last_d;
  logic [7:0]     bitn_q, bitn_d;
  logic [7:0]     sh_q, sh_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  step_t          cur;

  assign cur      = step_at(mode_q, step_q, raw_byte, raw_last);
  assign busy     = (st_q != S_IDLE);
  assign run_mode = mode_q;
  assign slot_rst = (kind_q == OP_RST);
  assign slot_bit = (kind_q == OP_RD) ? 1'b1 : sh_q[0];
  assign rd_idx   = bitn_q;
  assign rd_bit   = slot_rx;

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    step_d   = step_q;
    kind_d   = kind_q;
    last_d   = last_q;
    bitn_d   = bitn_q;
    sh_d     = sh_q;
    wcnt_d   = wcnt_q;
    fin      = 1'b0;
    slot_go  = 1'b0;
    tick_clr = 1'b0;
    rd_clr   = 1'b0;
    rd_we    = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        mode_d = start_mode;
        step_d = '0;
        st_d   = S_FETCH;
      end
      S_FETCH: begin
        kind_d = cur.kind;
        last_d = cur.last;
        sh_d   = cur.data;
        bitn_d = '0;
        case (cur.kind)
          OP_END: begin
            fin  = 1'b1;
            st_d = S_IDLE;
          end
          OP_WAIT: begin
            wcnt_d   = '0;
            tick_clr = 1'b1;
            st_d     = S_PAUSE;
          end
          OP_RD: begin
            rd_clr = 1'b1;
            st_d   = S_ISSUE;
          end
          default: st_d = S_ISSUE;
        endcase
      end
      S_ISSUE: begin
        slot_go  = 1'b1;
        tick_clr = 1'b1;
        st_d     = S_SLOT;
      end
      S_SLOT: if (slot_done) begin
        rd_we  = (kind_q == OP_RD);
        sh_d   = {1'b0, sh_q[7:1]};
        bitn_d = bitn_q + 1'b1;
        if (bitn_q == last_q) begin
          step_d = step_q + 1'b1;
          st_d   = S_FETCH;
        end else begin
          st_d = S_ISSUE;
        end
      end
      S_PAUSE: if (us_tick) begin
        wcnt_d = wcnt_q + 1'b1;
        if (wcnt_q == WAIT_M1) begin
          step_d = step_q + 1'b1;
          st_d   = S_FETCH;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      mode_q <= M_RST;
      step_q <= '0;
      kind_q <= OP_END;
      last_q <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      step_q <= step_d;
      kind_q <= kind_d;
      last_q <= last_d;
      bitn_q <= bitn_d;
      sh_q   <= sh_d;
      wcnt_q <= wcnt_d;
    end
  end

  // The slot engine only reports completion of a slot this FSM waits on.
  p_slot_handshake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> (st_q == S_SLOT));
endmodule

// File: rtl/onewire_xact_ctrl.sv
module onewire_xact_ctrl
  import owm_pkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int RD_REGS    = 5,
  parameter int CLK_PER_US = 125,
  parameter int CONV_US    = 750000,
  parameter int RST_LOW_US = 480,
  parameter int RST_REL_US = 410,
  parameter int SLOT_US    = 60,
  parameter int W1_LOW_US  = 6,
  parameter int W0_LOW_US  = 58,
  parameter int SAMPLE_US  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic [NUM_DEV-1:0] ow_drive_low,
  input  logic [NUM_DEV-1:0] ow_sense
);
  localparam int RD_BITS = RD_REGS * 16;
  localparam int RIW     = $clog2(RD_BITS);

  logic [NUM_DEV-1:0] sel_q, sel_d;
  logic [7:0]         last_q, last_d;
  logic [7:0]         byte_q, byte_d;
  logic               tdone_q, tdone_d, rdone_q, rdone_d;
  logic [RD_BITS-1:0] rbuf_q, rbuf_d;
  logic [1:0]         sync_q;

  logic       busy, fin, start, wr_ctrl, wr_cmd;
  mode_e      start_mode, run_mode;
  logic       us_tick, tick_clr, slot_go, slot_rst, slot_bit, slot_done, slot_rx;
  logic       drive, rd_clr, rd_we, rd_bit;
  logic [7:0] rd_idx;

  assign wr_ctrl = reg_wr && (reg_addr == 3'd0) && !busy;
  assign wr_cmd  = reg_wr && (reg_addr == 3'd1) && !busy;

  // Request decode with fixed priority: reset, write, read, temperature, ROM.
  always_comb begin
    start      = 1'b1;
    start_mode = M_RST;
    if      (wr_ctrl && reg_wdata[6]) start_mode = M_RST;
    else if (wr_ctrl && reg_wdata[4]) start_mode = M_WR;
    else if (wr_ctrl && reg_wdata[5]) start_mode = M_RD;
    else if (wr_cmd  && reg_wdata[8]) start_mode = M_TEMP;
    else if (wr_cmd  && reg_wdata[9]) start_mode = M_ROM;
    else                              start      = 1'b0;
  end

  always_comb begin
    sel_d   = sel_q;
    last_d  = last_q;
    byte_d  = byte_q;
    tdone_d = tdone_q;
    rdone_d = rdone_q;
    rbuf_d  = rbuf_q;
    if (wr_ctrl) begin
      sel_d  = reg_wdata[NUM_DEV-1:0];
      last_d = reg_wdata[15:8];
    end
    if (wr_cmd) byte_d = reg_wdata[7:0];
    if (start && start_mode == M_TEMP) tdone_d = 1'b0;
    if (start && start_mode == M_ROM)  rdone_d = 1'b0;
    if (fin && run_mode == M_TEMP) tdone_d = 1'b1;
    if (fin && run_mode == M_ROM)  rdone_d = 1'b1;
    if (rd_clr) rbuf_d = '0;
    if (rd_we && (rd_idx < 8'(RD_BITS))) rbuf_d[rd_idx[RIW-1:0]] = rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      last_q  <= '0;
      byte_q  <= '0;
      tdone_q <= 1'b0;
      rdone_q <= 1'b0;
      rbuf_q  <= '0;
      sync_q  <= 2'b11;
    end else begin
      sel_q   <= sel_d;
      last_q  <= last_d;
      byte_q  <= byte_d;
      tdone_q <= tdone_d;
      rdone_q <= rdone_d;
      rbuf_q  <= rbuf_d;
      sync_q  <= {sync_q[0], &(ow_sense | ~sel_q)};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: begin
        reg_rdata[15:8]        = last_q;
        reg_rdata[7]           = busy;
        reg_rdata[NUM_DEV-1:0] = sel_q;
      end
      3'd1: reg_rdata = {6'b0, rdone_q, tdone_q, byte_q};
      default: begin
        for (int k = 0; k < RD_REGS; k++)
          if (reg_addr == 3'(k + 2)) reg_rdata = rbuf_q[k*16 +: 16];
      end
    endcase
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_pin
    assign ow_drive_low[g] = drive && sel_q[g];
  end

  owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(us_tick)
  );

  owm_sequencer #(.CONV_US(CONV_US)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
    .raw_byte(byte_q), .raw_last(last_q), .us_tick(us_tick),
    .slot_done(slot_done), .slot_rx(slot_rx), .busy(busy), .fin(fin),
    .run_mode(run_mode), .slot_go(slot_go), .slot_rst(slot_rst),
    .slot_bit(slot_bit), .tick_clr(tick_clr), .rd_clr(rd_clr),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_bit(rd_bit)
  );

  owm_slot_engine #(
    .RST_LOW_US(RST_LOW_US), .RST_REL_US(RST_REL_US), .SLOT_US(SLOT_US),
    .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US), .SAMPLE_US(SAMPLE_US)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .go(slot_go),
    .go_rst(slot_rst), .go_bit(slot_bit), .line_in(sync_q[1]),
    .drive_low(drive), .done(slot_done), .rx_bit(slot_rx)
  );

  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ow_drive_low == '0));

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && busy) |=> ($stable(last_q) && $stable(sel_q)));

  p_rbuf_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(rbuf_q));
endmodule

// File: tb/tb_onewire_xact_ctrl.sv
module tb_onewire_xact_ctrl;
  localparam int C  = 2;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [ND-1:0] ow_drive_low;
  logic [ND-1:0] pull = '0;
  logic [ND-1:0] ow_sense;

  assign ow_sense = ~(ow_drive_low | pull);

  always #4 clk = ~clk;

  onewire_xact_ctrl #(.NUM_DEV(ND), .CLK_PER_US(C), .CONV_US(20)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ow_drive_low(ow_drive_low), .ow_sense(ow_sense)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];          // 0/1 = bit slot, 2 = reset pulse
  logic [ND-1:0] exp_sel = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: classify every pull-down pulse and compare with the scoreboard.
  int run = 0;
  always @(negedge clk) if (rst_n) begin
    if ((ow_drive_low & ~exp_sel) != '0) chk(0, "R1 unselected line driven", ow_drive_low, exp_sel);
    if (|ow_drive_low) run++;
    else if (run > 0) begin
      int code, exp_len, e;
      code    = (run < 30) ? 1 : (run < 300) ? 0 : 2;
      exp_len = (code == 2) ? 480*C : (code == 1) ? 6*C : 58*C;
      chk((run >= exp_len-2) && (run <= exp_len+2),
          (code == 2) ? "R2 reset low time" : "R3 slot low time", run, exp_len);
      if (exp_q.size() == 0) chk(0, "R6 unexpected bus event", code, -1);
      else begin
        e = exp_q.pop_front();
        chk(code == e, "R3 bus event order", code, e);
      end
      run = 0;
    end
  end

  // Bus device model: answers slots from resp_from on with pattern tx.
  int dev_line = 0;
  int slot_no = 0;
  int resp_from = 1000;
  int bitp = 0;
  int pull_left = 0;
  logic [127:0] tx = '0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (ow_drive_low[dev_line] && !prev) begin
      if (slot_no >= resp_from) begin
        if (!tx[bitp]) pull_left = 30*C;
        bitp++;
      end
      slot_no++;
    end
    prev = ow_drive_low[dev_line];
    pull = '0;
    if (pull_left > 0) begin
      pull[dev_line] = 1'b1;
      pull_left--;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    repeat (4) @(negedge clk);
    do rd(3'd0, v); while (v[7]);
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(int'(b[i]));
  endtask

  task automatic push_ones(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1);
  endtask

  task automatic arm(input int line, input int from, input logic [127:0] pat);
    dev_line = line; resp_from = from; tx = pat; slot_no = 0; bitp = 0;
  endtask

  task automatic chk_rd(input int nbits, input logic [127:0] pat, input string req);
    logic [15:0] v;
    logic [79:0] e;
    e = '0;
    for (int i = 0; i < 80; i++) if (i < nbits) e[i] = pat[i];
    for (int k = 0; k < 5; k++) begin
      rd(3'(k + 2), v);
      chk(v == e[k*16 +: 16], req, v, e[k*16 +: 16]);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    logic [127:0] pa, pb;
    pa = 128'h0123_4567_89AB_CDEF_5A3C_96E1_D2B4_7F08;
    pb = 128'hFEDC_BA98_7654_3210_C3A5_1E2D_0F69_B78E;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    for (int k = 0; k < 7; k++) begin
      rd(3'(k), v);
      chk(v == 16'h0, "R10 register after reset", v, 0);
    end
    chk(ow_drive_low == '0, "R10 no drive after reset", ow_drive_low, 0);

    // R1: field readback, no request bits
    exp_sel = 4'b0001;
    wr(3'd0, 16'h0701);
    rd(3'd0, v);
    chk(v == 16'h0701, "R1 control readback", v, 16'h0701);

    // R2 reset pulse, R5 busy
    exp_q.push_back(2);
    wr(3'd0, 16'h0741);
    repeat (3) @(negedge clk);
    rd(3'd0, v);
    chk(v == 16'h0781, "R5 busy during transaction", v, 16'h0781);
    wait_idle();
    rd(3'd0, v);
    chk(v == 16'h0701, "R5 busy clears after transaction", v, 16'h0701);

    // R3: 12-bit write of 0xA5
    wr(3'd1, 16'h00A5);
    push_byte(8'hA5); for (int i = 0; i < 4; i++) exp_q.push_back(0);
    wr(3'd0, 16'h0B11);
    wait_idle();
    chk(exp_q.size() == 0, "R3 all write slots seen", exp_q.size(), 0);

    // R4: 72-bit raw read
    arm(0, 0, pa);
    push_ones(72);
    wr(3'd0, 16'h4721);
    wait_idle();
    chk_rd(72, pa, "R4 72-bit read data");

    // R4: short read clears the read area
    arm(0, 0, pb);
    push_ones(4);
    wr(3'd0, 16'h0321);
    wait_idle();
    chk_rd(4, pb, "R4 short read clears area");

    // R4: read past capacity drops extra bits
    arm(0, 0, pa);
    push_ones(91);
    wr(3'd0, 16'h5A21);
    wait_idle();
    chk_rd(80, pa, "R4 overflow read keeps 80 bits");

    // R6: requests while busy are discarded
    arm(0, 1000, '0);
    wr(3'd1, 16'h003C);
    push_byte(8'h3C);
    wr(3'd0, 16'h0711);
    repeat (20) @(negedge clk);
    wr(3'd0, 16'h0355);
    wr(3'd1, 16'h02F0);
    rd(3'd0, v);
    chk(v == 16'h0781, "R6 control write ignored while busy", v, 16'h0781);
    rd(3'd1, v);
    chk(v == 16'h003C, "R6 command write ignored while busy", v, 16'h003C);
    wait_idle();
    chk(exp_q.size() == 0, "R6 no extra transaction", exp_q.size(), 0);

    // R7: all three raw requests at once -> reset only
    exp_q.push_back(2);
    wr(3'd0, 16'h0771);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(exp_q.size() == 0 && run == 0, "R7 reset wins over write and read", exp_q.size(), 0);

    // R1: select line 2, device on line 2
    exp_sel = 4'b0100;
    arm(2, 0, pb);
    push_ones(16);
    wr(3'd0, 16'h0F24);
    wait_idle();
    rd(3'd2, v);
    chk(v == pb[15:0], "R1 selected line read", v, pb[15:0]);

    // R1: pulls on an unselected line are not seen
    arm(0, 0, pb);
    push_ones(16);
    wr(3'd0, 16'h0F24);
    wait_idle();
    rd(3'd2, v);
    chk(v == 16'hFFFF, "R1 unselected line ignored", v, 16'hFFFF);

    // R8: ROM sequence
    exp_sel = 4'b0001;
    wr(3'd0, 16'h0001);
    arm(0, 9, pa);
    exp_q.push_back(2); push_byte(8'h33); push_ones(64);
    wr(3'd1, 16'h0200);
    repeat (3) @(negedge clk);
    rd(3'd1, v);
    chk(v[9] == 1'b0, "R8 ROM bit reads 0 while running", v[9], 0);
    wait_idle();
    rd(3'd1, v);
    chk(v == 16'h0200, "R8 ROM bit reads 1 when done", v, 16'h0200);
    chk(exp_q.size() == 0, "R8 ROM bus sequence complete", exp_q.size(), 0);
    chk_rd(64, pa, "R8 ROM data");

    // R9 temperature sequence, R7 temperature beats ROM
    arm(0, 34, pb);
    exp_q.push_back(2); push_byte(8'hCC); push_byte(8'h44);
    exp_q.push_back(2); push_byte(8'hCC); push_byte(8'hBE); push_ones(72);
    wr(3'd1, 16'h0300);
    repeat (3) @(negedge clk);
    rd(3'd1, v);
    chk(v == 16'h0200, "R9 temperature bit 0 while running, R7 ROM not restarted", v, 16'h0200);
    wait_idle();
    rd(3'd1, v);
    chk(v == 16'h0300, "R9 temperature bit set when done", v, 16'h0300);
    chk(exp_q.size() == 0, "R9 temperature bus sequence complete", exp_q.size(), 0);
    chk_rd(72, pb, "R9 temperature data");
    chk(ow_drive_low == '0, "R10 no drive when idle", ow_drive_low, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule